// File: doc/BRIEF.md
# Parallel Matrix-Vector Product Fault Corrector

This block guards four matrix-vector products that are computed side by side from one shared input vector. It receives the four N-element result vectors, three scalar results from a redundant detection matrix, and one N-element result from a redundant sum matrix. Each whole result vector is treated as one bit of a single-error-correcting code. For each vector the block adds up all of its elements, compares weighted groups of those totals with the three detection scalars, and decodes the pattern of mismatches. If one data vector is found faulty, every element of it is rebuilt from the sum-matrix result minus the other three vectors. Because detection works on whole-vector totals, any number of corrupted elements inside the one faulty vector is repaired.

Data enters through a valid/ready handshake and leaves through a second one. A source holds `in_valid` and all inputs stable until a transfer takes place. A transfer happens on a rising clock edge where both valid and ready are high. When the sink holds `out_ready` low, the result and its flags stay frozen and the two internal stages fill up, after which `in_ready` drops. No result is lost, duplicated or reordered.

Top module: `mvm_fault_corrector`

## Requirements
- R1: An input transfer occurs on a rising edge with `in_valid` and `in_ready` both high; `in_ready` is high whenever `out_valid` is low.
- R2: With `out_ready` held high, a result accepted on one rising edge shows `out_valid` high after the next rising edge (two register stages counting the capture register).
- R3: While `out_valid` is high and `out_ready` low, outputs and flags stay unchanged; with two results pending and `out_ready` low, `in_ready` is low; results leave in arrival order, each exactly once.
- R4: Element i of a data vector sits at bits [i*W +: W] as two's complement; check bit c1 is set when chk1 differs from total(z1)+total(z2)+total(z3), c2 likewise against z1,z2,z4, and c3 against z1,z3,z4. With all three clear, every output equals its input and all flags are zero.
- R5: The pattern {c1,c2,c3} decodes as 111 to z1, 110 to z2, 101 to z3 and 011 to z4, setting `bad_vec_o` bit 0, 1, 2 or 3 respectively.
- R6: The flagged vector is replaced elementwise by the sum-matrix element (bits [i*(W+2) +: W+2], two's complement) minus the three other vectors' elements, truncated to W bits; this repairs any number of corrupted elements in that vector.
- R7: Patterns 100, 010 and 001 mark a faulty detection scalar (chk1, chk2, chk3) by setting `bad_chk_o` bit 0, 1 or 2; all data vectors pass unchanged.
- R8: When no data vector is flagged, the sum-matrix input has no effect on any output.
- R9: At most one bit across `bad_vec_o` and `bad_chk_o` is set while `out_valid` is high.
- R10: During reset `out_valid` is low, `in_ready` is high and both flag fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers a set of results |
| in_ready | output | 1 | Block can take a set of results |
| z1_i | input | N*W | First data result vector |
| z2_i | input | N*W | Second data result vector |
| z3_i | input | N*W | Third data result vector |
| z4_i | input | N*W | Fourth data result vector |
| zsum_i | input | N*(W+2) | Sum-matrix result vector |
| chk1_i | input | W+clog2(N)+2 | First detection scalar |
| chk2_i | input | W+clog2(N)+2 | Second detection scalar |
| chk3_i | input | W+clog2(N)+2 | Third detection scalar |
| out_valid | output | 1 | Corrected results are presented |
| out_ready | input | 1 | Sink takes the presented results |
| y1_o | output | N*W | Corrected first vector |
| y2_o | output | N*W | Corrected second vector |
| y3_o | output | N*W | Corrected third vector |
| y4_o | output | N*W | Corrected fourth vector |
| bad_vec_o | output | 4 | One-hot: data vector that was rebuilt |
| bad_chk_o | output | 3 | One-hot: detection scalar judged faulty |

## Verification
The bench sweeps nine fault targets (none, each of the four data vectors, each of the three detection scalars, and the sum-matrix vector alone) across six data patterns, including all-maximum and all-minimum elements, and two corruption shapes: one damaged element, and three damaged elements with wrapping. The clean case separates pass-through from false correction, each data-vector target checks both the decode table and the arithmetic rebuild, scalar targets show that a damaged check result leaves data alone, and the sum-matrix target shows that input is unused without a flagged vector. The same items are streamed with gaps on the input and stalls on the output, which tells apart correct holding and ordering from lost or repeated results.

// File: rtl/mvmft_pkg.sv
`timescale 1ns/1ps
package mvmft_pkg;
  localparam int NVEC = 4;
  localparam int NCHK = 3;

  // Mismatch pattern {c1,c2,c3}; c1 is the most significant bit.
  typedef enum logic [2:0] {
    SYN_CLEAN = 3'b000,
    SYN_CHK3  = 3'b001,
    SYN_CHK2  = 3'b010,
    SYN_Z4    = 3'b011,
    SYN_CHK1  = 3'b100,
    SYN_Z3    = 3'b101,
    SYN_Z2    = 3'b110,
    SYN_Z1    = 3'b111
  } syn_e;

  // Check j covers every data vector except vector (3 - j).
  function automatic logic in_check(input int j, input int k);
    return (k != (NVEC - 1 - j));
  endfunction
endpackage

// File: rtl/mvmft_total.sv
`timescale 1ns/1ps
module mvmft_total #(
  parameter int N = 20,
  parameter int W = 21,
  localparam int TW = W + $clog2(N)
) (
  input  logic [N*W-1:0]        vec_i,
  output logic signed [TW-1:0]  total_o
);
  always_comb begin
    total_o = '0;
    for (int i = 0; i < N; i++) begin
      total_o = total_o + TW'(signed'(vec_i[i*W +: W]));
    end
  end
endmodule

// File: rtl/mvmft_syndrome.sv
`timescale 1ns/1ps
module mvmft_syndrome
  import mvmft_pkg::*;
#(
  parameter int TW = 26,
  parameter int SW = 28
) (
  input  logic signed [TW-1:0] tot_i [NVEC],
  input  logic signed [SW-1:0] chk_i [NCHK],
  output logic [NVEC-1:0]      bad_vec_o,
  output logic [NCHK-1:0]      bad_chk_o
);
  logic signed [SW-1:0] group_sum [NCHK];
  logic [NCHK-1:0]      syn;

  always_comb begin
    for (int j = 0; j < NCHK; j++) begin
      group_sum[j] = '0;
      for (int k = 0; k < NVEC; k++) begin
        if (in_check(j, k)) group_sum[j] = group_sum[j] + SW'(tot_i[k]);
      end
      syn[NCHK-1-j] = (chk_i[j] != group_sum[j]);
    end
  end

  always_comb begin
    bad_vec_o = '0;
    bad_chk_o = '0;
    case (syn_e'(syn))
      SYN_Z1:   bad_vec_o[0] = 1'b1;
      SYN_Z2:   bad_vec_o[1] = 1'b1;
      SYN_Z3:   bad_vec_o[2] = 1'b1;
      SYN_Z4:   bad_vec_o[3] = 1'b1;
      SYN_CHK1: bad_chk_o[0] = 1'b1;
      SYN_CHK2: bad_chk_o[1] = 1'b1;
      SYN_CHK3: bad_chk_o[2] = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/mvmft_rebuild.sv
`timescale 1ns/1ps
module mvmft_rebuild
  import mvmft_pkg::*;
#(
  parameter int N = 20,
  parameter int W = 21,
  localparam int ZW = W + 2
) (
  input  logic [N*W-1:0]  z_i [NVEC],
  input  logic [N*ZW-1:0] zsum_i,
  input  logic [NVEC-1:0] sel_i,
  output logic [N*W-1:0]  y_o [NVEC]
);
  for (genvar k = 0; k < NVEC; k++) begin : g_vec
    logic [N*W-1:0] outv;
    for (genvar i = 0; i < N; i++) begin : g_elem
      logic signed [ZW-1:0] rest;
      logic signed [ZW-1:0] fixed;
      always_comb begin
        rest = '0;
        for (int j = 0; j < NVEC; j++) begin
          if (j != k) rest = rest + ZW'(signed'(z_i[j][i*W +: W]));
        end
        fixed = signed'(zsum_i[i*ZW +: ZW]) - rest;
      end
      assign outv[i*W +: W] = sel_i[k] ? fixed[W-1:0] : z_i[k][i*W +: W];
    end
    assign y_o[k] = outv;
  end
endmodule

// File: rtl/mvm_fault_corrector.sv
`timescale 1ns/1ps
module mvm_fault_corrector
  import mvmft_pkg::*;
#(
  parameter int N = 20,
  parameter int W = 21,
  localparam int ZW = W + 2,
  localparam int TW = W + $clog2(N),
  localparam int SW = TW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [N*W-1:0]  z1_i,
  input  logic [N*W-1:0]  z2_i,
  input  logic [N*W-1:0]  z3_i,
  input  logic [N*W-1:0]  z4_i,
  input  logic [N*ZW-1:0] zsum_i,
  input  logic [SW-1:0]   chk1_i,
  input  logic [SW-1:0]   chk2_i,
  input  logic [SW-1:0]   chk3_i,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [N*W-1:0]  y1_o,
  output logic [N*W-1:0]  y2_o,
  output logic [N*W-1:0]  y3_o,
  output logic [N*W-1:0]  y4_o,
  output logic [3:0]      bad_vec_o,
  output logic [2:0]      bad_chk_o
);
  logic [N*W-1:0]        z_in   [NVEC];
  logic signed [SW-1:0]  chk_in [NCHK];
  logic signed [TW-1:0]  tot_c  [NVEC];

  assign z_in[0]   = z1_i;
  assign z_in[1]   = z2_i;
  assign z_in[2]   = z3_i;
  assign z_in[3]   = z4_i;
  assign chk_in[0] = chk1_i;
  assign chk_in[1] = chk2_i;
  assign chk_in[2] = chk3_i;

  // Stage 1: capture inputs and the per-vector totals.
  for (genvar k = 0; k < NVEC; k++) begin : g_tot
    mvmft_total #(.N(N), .W(W)) u_total (
      .vec_i   (z_in[k]),
      .total_o (tot_c[k])
    );
  end

  logic                  st1_vld;
  logic [N*W-1:0]        st1_z    [NVEC];
  logic [N*ZW-1:0]       st1_zsum;
  logic signed [SW-1:0]  st1_chk  [NCHK];
  logic signed [TW-1:0]  st1_tot  [NVEC];
  logic                  adv2;

  assign adv2     = !out_valid || out_ready;
  assign in_ready = !st1_vld || adv2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_vld  <= 1'b0;
      st1_zsum <= '0;
      for (int k = 0; k < NVEC; k++) begin
        st1_z[k]   <= '0;
        st1_tot[k] <= '0;
      end
      for (int j = 0; j < NCHK; j++) st1_chk[j] <= '0;
    end else if (in_ready) begin
      st1_vld <= in_valid;
      if (in_valid) begin
        st1_zsum <= zsum_i;
        for (int k = 0; k < NVEC; k++) begin
          st1_z[k]   <= z_in[k];
          st1_tot[k] <= tot_c[k];
        end
        for (int j = 0; j < NCHK; j++) st1_chk[j] <= chk_in[j];
      end
    end
  end

  // Stage 2: decode mismatches, rebuild the flagged vector, register.
  logic [NVEC-1:0] bad_vec_c;
  logic [NCHK-1:0] bad_chk_c;
  logic [N*W-1:0]  y_c [NVEC];
  logic [N*W-1:0]  y_q [NVEC];

  mvmft_syndrome #(.TW(TW), .SW(SW)) u_syndrome (
    .tot_i     (st1_tot),
    .chk_i     (st1_chk),
    .bad_vec_o (bad_vec_c),
    .bad_chk_o (bad_chk_c)
  );

  mvmft_rebuild #(.N(N), .W(W)) u_rebuild (
    .z_i    (st1_z),
    .zsum_i (st1_zsum),
    .sel_i  (bad_vec_c),
    .y_o    (y_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      bad_vec_o <= '0;
      bad_chk_o <= '0;
      for (int k = 0; k < NVEC; k++) y_q[k] <= '0;
    end else if (adv2) begin
      out_valid <= st1_vld;
      if (st1_vld) begin
        bad_vec_o <= bad_vec_c;
        bad_chk_o <= bad_chk_c;
        for (int k = 0; k < NVEC; k++) y_q[k] <= y_c[k];
      end
    end
  end

  assign y1_o = y_q[0];
  assign y2_o = y_q[1];
  assign y3_o = y_q[2];
  assign y4_o = y_q[3];
endmodule

// File: rtl/mvmft_checker.sv
`timescale 1ns/1ps
module mvmft_checker #(
  parameter int N = 20,
  parameter int W = 21
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [N*W-1:0] y1_o,
  input logic [N*W-1:0] y2_o,
  input logic [N*W-1:0] y3_o,
  input logic [N*W-1:0] y4_o,
  input logic [3:0]     bad_vec_o,
  input logic [2:0]     bad_chk_o
);
  // R10
  p_reset_idle_r10: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && bad_vec_o == '0 && bad_chk_o == '0));

  // R1
  p_ready_drained_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);

  // R3
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(y1_o) && $stable(y2_o)
      && $stable(y3_o) && $stable(y4_o) && $stable(bad_vec_o) && $stable(bad_chk_o)));

  // R9
  p_flag_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({bad_vec_o, bad_chk_o}));
endmodule

bind mvm_fault_corrector mvmft_checker #(.N(N), .W(W)) u_mvmft_checker (.*);

// File: tb/tb_mvm_fault_corrector.sv
`timescale 1ns/1ps
module tb_mvm_fault_corrector;
  localparam int N  = 4;
  localparam int W  = 6;
  localparam int ZW = W + 2;
  localparam int SW = W + $clog2(N) + 2;
  localparam int NT = 9;   // fault targets
  localparam int NP = 6;   // data patterns
  localparam int NS = 2;   // corruption shapes
  localparam int NI = NT * NP * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*W-1:0]  z1_i = '0, z2_i = '0, z3_i = '0, z4_i = '0;
  logic [N*ZW-1:0] zsum_i = '0;
  logic [SW-1:0]   chk1_i = '0, chk2_i = '0, chk3_i = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [N*W-1:0] y1_o, y2_o, y3_o, y4_o;
  logic [3:0] bad_vec_o;
  logic [2:0] bad_chk_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mvm_fault_corrector #(.N(N), .W(W)) dut (.*);

  logic [N*W-1:0]  st_z  [NI][4];
  logic [N*ZW-1:0] st_zs [NI];
  logic [SW-1:0]   st_c  [NI][3];
  logic [N*W-1:0]  ex_y  [NI][4];
  logic [3:0]      ex_v  [NI];
  logic [2:0]      ex_c  [NI];
  int              tgt_of[NI];

  function automatic int gen(int p, int k, int i);
    if (p == 4) return 31;
    if (p == 5) return -32;
    return ((p * 53 + k * 17 + i * 29 + 7) % 64) - 32;
  endfunction

  task automatic build(int idx, int tgt, int p, int sh);
    int good [4][N];
    int tot [4];
    int d, s, c;
    d = 1 + (p % 3);
    tgt_of[idx] = tgt;
    for (int k = 0; k < 4; k++) begin
      tot[k] = 0;
      for (int i = 0; i < N; i++) begin
        good[k][i] = gen(p, k, i);
        tot[k] += good[k][i];
        st_z[idx][k][i*W +: W] = good[k][i][W-1:0];
        ex_y[idx][k][i*W +: W] = good[k][i][W-1:0];
      end
    end
    for (int i = 0; i < N; i++) begin
      s = good[0][i] + good[1][i] + good[2][i] + good[3][i];
      st_zs[idx][i*ZW +: ZW] = s[ZW-1:0];
    end
    for (int j = 0; j < 3; j++) begin
      c = 0;
      for (int k = 0; k < 4; k++) if (k != 3 - j) c += tot[k];
      st_c[idx][j] = c[SW-1:0];
    end
    ex_v[idx] = '0;
    ex_c[idx] = '0;
    if (tgt >= 1 && tgt <= 4) begin
      ex_v[idx][tgt-1] = 1'b1;
      if (sh == 0) begin
        st_z[idx][tgt-1][1*W +: W] = st_z[idx][tgt-1][1*W +: W] + W'(d);
      end else begin
        st_z[idx][tgt-1][0*W +: W] = st_z[idx][tgt-1][0*W +: W] + W'(d);
        st_z[idx][tgt-1][2*W +: W] = st_z[idx][tgt-1][2*W +: W] + W'(d);
        st_z[idx][tgt-1][3*W +: W] = st_z[idx][tgt-1][3*W +: W] + W'(2 * d);
      end
    end else if (tgt >= 5 && tgt <= 7) begin
      ex_c[idx][tgt-5] = 1'b1;
      st_c[idx][tgt-5] = st_c[idx][tgt-5] + SW'(d * (sh + 1));
    end else if (tgt == 8) begin
      st_zs[idx][0 +: ZW] = st_zs[idx][0 +: ZW] + ZW'(d * (sh + 1));
      st_zs[idx][2*ZW +: ZW] = st_zs[idx][2*ZW +: ZW] + ZW'(5);
    end
  endtask

  task automatic drive(int idx);
    z1_i = st_z[idx][0]; z2_i = st_z[idx][1];
    z3_i = st_z[idx][2]; z4_i = st_z[idx][3];
    zsum_i = st_zs[idx];
    chk1_i = st_c[idx][0]; chk2_i = st_c[idx][1]; chk3_i = st_c[idx][2];
  endtask

  task automatic compare(int idx);
    string tag;
    case (tgt_of[idx])
      0: tag = "R4";
      1, 2, 3, 4: tag = "R6";
      5, 6, 7: tag = "R7";
      default: tag = "R8";
    endcase
    checks++;
    if (y1_o !== ex_y[idx][0] || y2_o !== ex_y[idx][1] ||
        y3_o !== ex_y[idx][2] || y4_o !== ex_y[idx][3]) begin
      fails++;
      $display("FAIL %s item %0d data: got %h %h %h %h exp %h %h %h %h", tag, idx,
               y1_o, y2_o, y3_o, y4_o, ex_y[idx][0], ex_y[idx][1], ex_y[idx][2], ex_y[idx][3]);
    end
    checks++;
    if (bad_vec_o !== ex_v[idx] || bad_chk_o !== ex_c[idx]) begin
      fails++;
      $display("FAIL %s item %0d flags (R5 decode): got vec=%b chk=%b exp vec=%b chk=%b",
               tag, idx, bad_vec_o, bad_chk_o, ex_v[idx], ex_c[idx]);
    end
    checks++;
    if (!$onehot0({bad_vec_o, bad_chk_o})) begin
      fails++;
      $display("FAIL R9 item %0d: flags %b%b exp at most one set", idx, bad_vec_o, bad_chk_o);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    summary();
    $finish;
  end

  initial begin
    int idx, iidx, oidx, cyc;
    logic held;
    logic [N*W-1:0] h1, h2, h3, h4;
    logic [3:0] hv;
    logic [2:0] hc;
    idx = 0;
    for (int t = 0; t < NT; t++)
      for (int p = 0; p < NP; p++)
        for (int s = 0; s < NS; s++) begin
          build(idx, t, p, s);
          idx++;
        end

    // Reset state (R10, R1)
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1 || bad_vec_o !== '0 || bad_chk_o !== '0) begin
      fails++;
      $display("FAIL R10 reset: got ov=%b ir=%b vec=%b chk=%b exp 0 1 0 0",
               out_valid, in_ready, bad_vec_o, bad_chk_o);
    end
    rst_n = 1'b1;

    // Latency (R2) with a z2 fault item
    @(negedge clk);
    drive(NP * NS * 2);
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2 early: got out_valid=%b exp 0", out_valid);
    end
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1) begin
      fails++;
      $display("FAIL R2 latency: got out_valid=%b exp 1", out_valid);
    end
    if (out_valid === 1'b1) compare(NP * NS * 2);
    @(negedge clk);

    // Streaming sweep with gaps and stalls (R1, R3 and all functions)
    iidx = 0; oidx = 0; cyc = 0; held = 1'b0;
    h1 = '0; h2 = '0; h3 = '0; h4 = '0; hv = '0; hc = '0;
    while (oidx < NI && cyc < 5000) begin
      in_valid = (iidx < NI) && (cyc % 11 != 4);
      if (iidx < NI) drive(iidx);
      out_ready = (cyc % 5 != 2) && (cyc % 7 != 3) && !(cyc >= 20 && cyc < 28);
      #1;
      if (held) begin
        checks++;
        if (out_valid !== 1'b1 || y1_o !== h1 || y2_o !== h2 || y3_o !== h3 ||
            y4_o !== h4 || bad_vec_o !== hv || bad_chk_o !== hc) begin
          fails++;
          $display("FAIL R3 hold: got ov=%b y1=%h vec=%b exp ov=1 y1=%h vec=%b",
                   out_valid, y1_o, bad_vec_o, h1, hv);
        end
      end
      if (iidx - oidx == 2 && !out_ready) begin
        checks++;
        if (in_ready !== 1'b0) begin
          fails++;
          $display("FAIL R3 full: got in_ready=%b exp 0", in_ready);
        end
      end
      if (!out_valid) begin
        checks++;
        if (in_ready !== 1'b1) begin
          fails++;
          $display("FAIL R1 ready: got in_ready=%b exp 1", in_ready);
        end
      end
      held = out_valid && !out_ready;
      h1 = y1_o; h2 = y2_o; h3 = y3_o; h4 = y4_o; hv = bad_vec_o; hc = bad_chk_o;
      if (out_valid && out_ready) begin
        compare(oidx);
        oidx++;
      end
      if (in_valid && in_ready) iidx++;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    checks++;
    if (oidx != NI) begin
      fails++;
      $display("FAIL R3 count: got %0d results exp %0d", oidx, NI);
    end
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R3 extra result: got out_valid=%b exp 0", out_valid);
    end
    summary();
    $finish;
  end
endmodule